// File: doc/BRIEF.md
# Processor status register pair

This block holds the two 16-bit status/control words of a DSP core. The first word carries a 3-bit auxiliary-register pointer, an overflow flag, an overflow-mode bit, the interrupt mask and a 9-bit data page pointer. The second word carries a 3-bit pointer buffer, a configuration bit, a test/control flag, a sign-extension mode bit, a carry bit, an external flag output bit and a 2-bit product-mode field.

Surrounding logic writes the words in four ways. A whole-word load restores a saved image. A single-bit set/clear sets or clears one control bit. A pointer-update port writes a new pointer and saves the old pointer in the buffer. Three flag inputs with their own enables write the overflow, carry and test/control flags. Both words are always visible on the outputs, so the machine state can be saved and restored later.

Top module: `dsp_status_regs`

## Requirements
- R1: Word 0 (`st0_o`) has this layout: bits 15:13 pointer, bit 12 overflow flag, bit 11 overflow mode, bit 10 reserved, bit 9 interrupt mask, bits 8:0 data page.
- R2: Word 1 (`st1_o`) has this layout: bits 15:13 pointer buffer, bit 12 configuration, bit 11 test/control, bit 10 sign-extension mode, bit 9 carry, bits 8:5 reserved, bit 4 external flag, bits 3:2 reserved, bits 1:0 product mode.
- R3: Reserved bits always read 1, whatever value is loaded.
- R4: When `ptr_en_i` is high and no load is active, on the next edge the pointer takes `ptr_val_i` and the buffer takes the old pointer.
- R5: A load of word 0 (`ld_en_i`=1, `ld_sel_i`=0) writes the pointer, overflow flag, overflow mode and data page from `ld_data_i`. It leaves the buffer and the interrupt mask unchanged.
- R6: A load of word 1 (`ld_en_i`=1, `ld_sel_i`=1) writes all writable fields of word 1 from `ld_data_i`. It also writes `ld_data_i[15:13]` into the pointer.
- R7: When `bit_en_i` is high, the bit named by `bit_sel_i` takes `bit_val_i`. The codes are: 0 interrupt mask, 1 overflow mode, 2 configuration, 3 sign-extension mode, 4 test/control, 5 carry, 6 external flag. Code 7 changes nothing.
- R8: Priority per field is: whole-word load, then single-bit set/clear, then the flag inputs. A pointer update is ignored while any load is active.
- R9: `ov_we_i`, `c_we_i` and `tc_we_i` write `ov_i`, `c_i` and `tc_i` into their flags on the clock edge, unless a higher-priority source writes that flag.
- R10: After reset all writable fields are 0 except the interrupt mask, which is 1. So `st0_o`=16'h0600 and `st1_o`=16'h01EC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_en_i | input | 1 | Whole-word load strobe |
| ld_sel_i | input | 1 | Load target: 0 word 0, 1 word 1 |
| ld_data_i | input | 16 | Load image |
| bit_en_i | input | 1 | Single-bit set/clear strobe |
| bit_sel_i | input | 3 | Bit code, see R7 |
| bit_val_i | input | 1 | Value written to the selected bit |
| ptr_en_i | input | 1 | Pointer update strobe |
| ptr_val_i | input | 3 | New pointer value |
| ov_we_i | input | 1 | Overflow flag write enable |
| ov_i | input | 1 | Overflow flag value |
| c_we_i | input | 1 | Carry write enable |
| c_i | input | 1 | Carry value |
| tc_we_i | input | 1 | Test/control write enable |
| tc_i | input | 1 | Test/control value |
| st0_o | output | 16 | Status word 0 |
| st1_o | output | 16 | Status word 1 |

## Verification
The hardest situation to reach is a cycle in which several write sources aim at the same field. Examples are a word-1 load together with a pointer update and a test/control set/clear, or a word-0 load together with an interrupt-mask set/clear. These collisions are rare unless the strobes are driven together. The stimulus applies them in directed cycles. Random cycles then raise each strobe with high probability, so collisions recur many times over a long run.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int REG_W = 16;
  localparam int PTR_W = 3;
  localparam int DP_W  = 9;
  localparam int PM_W  = 2;
  localparam int SEL_W = 3;

  localparam int PTR_LSB = REG_W - PTR_W;

  localparam logic [REG_W-1:0] ST0_RSV = 16'h0400;
  localparam logic [REG_W-1:0] ST1_RSV = 16'h01EC;

  typedef enum logic [SEL_W-1:0] {
    BIT_INTM = 3'd0,
    BIT_OVM  = 3'd1,
    BIT_CNF  = 3'd2,
    BIT_SXM  = 3'd3,
    BIT_TC   = 3'd4,
    BIT_C    = 3'd5,
    BIT_XF   = 3'd6,
    BIT_NONE = 3'd7
  } bit_sel_e;
endpackage

// File: rtl/ptr_unit.sv
module ptr_unit
  import stat_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld0_i,
  input  logic             ld1_i,
  input  logic [PTR_W-1:0] ld_ptr_i,
  input  logic             upd_i,
  input  logic [PTR_W-1:0] upd_val_i,
  output logic [PTR_W-1:0] arp_o,
  output logic [PTR_W-1:0] arb_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arp_o <= '0;
      arb_o <= '0;
    end else if (ld1_i) begin
      arb_o <= ld_ptr_i;
      arp_o <= ld_ptr_i;
    end else if (ld0_i) begin
      arp_o <= ld_ptr_i;  // no save into buffer
    end else if (upd_i) begin
      arb_o <= arp_o;
      arp_o <= upd_val_i;
    end
  end

  p_ptr_save_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !ld0_i && !ld1_i) |=> (arb_o == $past(arp_o) && arp_o == $past(upd_val_i)));
  p_ld1_copy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld1_i |=> (arp_o == arb_o && arp_o == $past(ld_ptr_i)));
  p_ld0_keep_buf_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld0_i && !ld1_i) |=> $stable(arb_o));
endmodule

// File: rtl/st0_fields.sv
module st0_fields
  import stat_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ld_i,
  input  logic            ld_ov_i,
  input  logic            ld_ovm_i,
  input  logic [DP_W-1:0] ld_dp_i,
  input  logic            bit_en_i,
  input  bit_sel_e        bit_sel_i,
  input  logic            bit_val_i,
  input  logic            ov_we_i,
  input  logic            ov_i,
  output logic            ov_o,
  output logic            ovm_o,
  output logic            intm_o,
  output logic [DP_W-1:0] dp_o
);
  logic hit_intm, hit_ovm;
  assign hit_intm = bit_en_i && (bit_sel_i == BIT_INTM);
  assign hit_ovm  = bit_en_i && (bit_sel_i == BIT_OVM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ov_o   <= 1'b0;
      ovm_o  <= 1'b0;
      intm_o <= 1'b1;
      dp_o   <= '0;
    end else begin
      if (ld_i) begin
        ov_o  <= ld_ov_i;
        ovm_o <= ld_ovm_i;
        dp_o  <= ld_dp_i;
      end else begin
        if (hit_ovm) ovm_o <= bit_val_i;
        if (ov_we_i) ov_o  <= ov_i;
      end
      if (hit_intm) intm_o <= bit_val_i;  // mask is written only here
    end
  end

  p_intm_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !hit_intm) |=> $stable(intm_o));
  p_ld_over_bit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && hit_ovm) |=> (ovm_o == $past(ld_ovm_i)));
  p_ov_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ov_we_i && !ld_i) |=> (ov_o == $past(ov_i)));
endmodule

// File: rtl/st1_fields.sv
module st1_fields
  import stat_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ld_i,
  input  logic            ld_cnf_i,
  input  logic            ld_tc_i,
  input  logic            ld_sxm_i,
  input  logic            ld_c_i,
  input  logic            ld_xf_i,
  input  logic [PM_W-1:0] ld_pm_i,
  input  logic            bit_en_i,
  input  bit_sel_e        bit_sel_i,
  input  logic            bit_val_i,
  input  logic            tc_we_i,
  input  logic            tc_i,
  input  logic            c_we_i,
  input  logic            c_i,
  output logic            cnf_o,
  output logic            tc_o,
  output logic            sxm_o,
  output logic            c_o,
  output logic            xf_o,
  output logic [PM_W-1:0] pm_o
);
  logic hit_cnf, hit_tc, hit_sxm, hit_c, hit_xf;
  assign hit_cnf = bit_en_i && (bit_sel_i == BIT_CNF);
  assign hit_tc  = bit_en_i && (bit_sel_i == BIT_TC);
  assign hit_sxm = bit_en_i && (bit_sel_i == BIT_SXM);
  assign hit_c   = bit_en_i && (bit_sel_i == BIT_C);
  assign hit_xf  = bit_en_i && (bit_sel_i == BIT_XF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnf_o <= 1'b0;
      tc_o  <= 1'b0;
      sxm_o <= 1'b0;
      c_o   <= 1'b0;
      xf_o  <= 1'b0;
      pm_o  <= '0;
    end else if (ld_i) begin
      cnf_o <= ld_cnf_i;
      tc_o  <= ld_tc_i;
      sxm_o <= ld_sxm_i;
      c_o   <= ld_c_i;
      xf_o  <= ld_xf_i;
      pm_o  <= ld_pm_i;
    end else begin
      if (hit_cnf) cnf_o <= bit_val_i;
      if (hit_sxm) sxm_o <= bit_val_i;
      if (hit_xf)  xf_o  <= bit_val_i;
      if (hit_tc)       tc_o <= bit_val_i;
      else if (tc_we_i) tc_o <= tc_i;
      if (hit_c)        c_o  <= bit_val_i;
      else if (c_we_i)  c_o  <= c_i;
    end
  end

  p_bit_over_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && hit_c && c_we_i) |=> (c_o == $past(bit_val_i)));
  p_tc_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_we_i && !ld_i && !hit_tc) |=> (tc_o == $past(tc_i)));
  p_sxm_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_sxm && !ld_i) |=> (sxm_o == $past(bit_val_i)));
endmodule

// File: rtl/dsp_status_regs.sv
module dsp_status_regs
  import stat_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_en_i,
  input  logic             ld_sel_i,
  input  logic [REG_W-1:0] ld_data_i,
  input  logic             bit_en_i,
  input  logic [SEL_W-1:0] bit_sel_i,
  input  logic             bit_val_i,
  input  logic             ptr_en_i,
  input  logic [PTR_W-1:0] ptr_val_i,
  input  logic             ov_we_i,
  input  logic             ov_i,
  input  logic             c_we_i,
  input  logic             c_i,
  input  logic             tc_we_i,
  input  logic             tc_i,
  output logic [REG_W-1:0] st0_o,
  output logic [REG_W-1:0] st1_o
);
  logic ld0, ld1;
  bit_sel_e sel;
  logic [PTR_W-1:0] arp, arb;
  logic ov, ovm, intm, cnf, tc, sxm, c, xf;
  logic [DP_W-1:0] dp;
  logic [PM_W-1:0] pm;

  assign ld0 = ld_en_i && !ld_sel_i;
  assign ld1 = ld_en_i &&  ld_sel_i;
  assign sel = bit_sel_e'(bit_sel_i);

  ptr_unit u_ptr (
    .clk_i, .rst_ni,
    .ld0_i(ld0), .ld1_i(ld1),
    .ld_ptr_i(ld_data_i[REG_W-1:PTR_LSB]),
    .upd_i(ptr_en_i), .upd_val_i(ptr_val_i),
    .arp_o(arp), .arb_o(arb)
  );

  st0_fields u_st0 (
    .clk_i, .rst_ni,
    .ld_i(ld0),
    .ld_ov_i(ld_data_i[12]), .ld_ovm_i(ld_data_i[11]),
    .ld_dp_i(ld_data_i[DP_W-1:0]),
    .bit_en_i, .bit_sel_i(sel), .bit_val_i,
    .ov_we_i, .ov_i,
    .ov_o(ov), .ovm_o(ovm), .intm_o(intm), .dp_o(dp)
  );

  st1_fields u_st1 (
    .clk_i, .rst_ni,
    .ld_i(ld1),
    .ld_cnf_i(ld_data_i[12]), .ld_tc_i(ld_data_i[11]),
    .ld_sxm_i(ld_data_i[10]), .ld_c_i(ld_data_i[9]),
    .ld_xf_i(ld_data_i[4]), .ld_pm_i(ld_data_i[PM_W-1:0]),
    .bit_en_i, .bit_sel_i(sel), .bit_val_i,
    .tc_we_i, .tc_i, .c_we_i, .c_i,
    .cnf_o(cnf), .tc_o(tc), .sxm_o(sxm), .c_o(c), .xf_o(xf), .pm_o(pm)
  );

  always_comb begin
    st0_o = ST0_RSV;
    st0_o[REG_W-1:PTR_LSB] = arp;
    st0_o[12]              = ov;
    st0_o[11]              = ovm;
    st0_o[9]               = intm;
    st0_o[DP_W-1:0]        = dp;
  end

  always_comb begin
    st1_o = ST1_RSV;
    st1_o[REG_W-1:PTR_LSB] = arb;
    st1_o[12]              = cnf;
    st1_o[11]              = tc;
    st1_o[10]              = sxm;
    st1_o[9]               = c;
    st1_o[4]               = xf;
    st1_o[PM_W-1:0]        = pm;
  end

  p_xf_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && sel == BIT_XF && !ld1) |=> (st1_o[4] == $past(bit_val_i)));
  p_rsv1_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld1 |=> ((st1_o & ST1_RSV) == ST1_RSV));
  p_ptr_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_en_i && ptr_en_i) |=> (st0_o[REG_W-1:PTR_LSB] == $past(ld_data_i[REG_W-1:PTR_LSB])));
endmodule

// File: tb/sim_dsp_status_regs.sv
module sim_dsp_status_regs;
  localparam int CLK_P = 10;
  localparam int N_RAND = 3000;

  logic clk = 0, rst_ni = 0;
  logic ld_en = 0, ld_sel = 0, bit_en = 0, bit_val = 0, ptr_en = 0;
  logic [15:0] ld_data = '0;
  logic [2:0] bit_sel = '0, ptr_val = '0;
  logic ov_we = 0, ov = 0, c_we = 0, c = 0, tc_we = 0, tc = 0;
  logic [15:0] st0, st1;

  int checks = 0, errors = 0;

  logic [2:0] m_arp, m_arb;
  logic m_ov, m_ovm, m_intm, m_cnf, m_tc, m_sxm, m_c, m_xf;
  logic [8:0] m_dp;
  logic [1:0] m_pm;

  always #(CLK_P/2) clk = ~clk;

  dsp_status_regs u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .ld_en_i(ld_en), .ld_sel_i(ld_sel), .ld_data_i(ld_data),
    .bit_en_i(bit_en), .bit_sel_i(bit_sel), .bit_val_i(bit_val),
    .ptr_en_i(ptr_en), .ptr_val_i(ptr_val),
    .ov_we_i(ov_we), .ov_i(ov), .c_we_i(c_we), .c_i(c),
    .tc_we_i(tc_we), .tc_i(tc),
    .st0_o(st0), .st1_o(st1)
  );

  function automatic logic [15:0] exp0();
    return {m_arp, m_ov, m_ovm, 1'b1, m_intm, m_dp};
  endfunction

  function automatic logic [15:0] exp1();
    return {m_arb, m_cnf, m_tc, m_sxm, m_c, 4'hF, m_xf, 2'b11, m_pm};
  endfunction

  task automatic model_reset();
    m_arp = 0; m_arb = 0; m_ov = 0; m_ovm = 0; m_intm = 1; m_dp = 0;
    m_cnf = 0; m_tc = 0; m_sxm = 0; m_c = 0; m_xf = 0; m_pm = 0;
  endtask

  task automatic model_step();
    logic l0, l1, b;
    l0 = ld_en && !ld_sel;
    l1 = ld_en && ld_sel;
    b  = bit_en;
    if (l1) begin m_arb = ld_data[15:13]; m_arp = ld_data[15:13]; end
    else if (l0) m_arp = ld_data[15:13];
    else if (ptr_en) begin m_arb = m_arp; m_arp = ptr_val; end
    if (b && bit_sel == 3'd0) m_intm = bit_val;
    if (l0) begin m_ov = ld_data[12]; m_ovm = ld_data[11]; m_dp = ld_data[8:0]; end
    else begin
      if (b && bit_sel == 3'd1) m_ovm = bit_val;
      if (ov_we) m_ov = ov;
    end
    if (l1) begin
      m_cnf = ld_data[12]; m_tc = ld_data[11]; m_sxm = ld_data[10];
      m_c = ld_data[9]; m_xf = ld_data[4]; m_pm = ld_data[1:0];
    end else begin
      if (b && bit_sel == 3'd2) m_cnf = bit_val;
      if (b && bit_sel == 3'd3) m_sxm = bit_val;
      if (b && bit_sel == 3'd6) m_xf = bit_val;
      if (b && bit_sel == 3'd4) m_tc = bit_val; else if (tc_we) m_tc = tc;
      if (b && bit_sel == 3'd5) m_c = bit_val; else if (c_we) m_c = c;
    end
  endtask

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ld_en = 0; bit_en = 0; ptr_en = 0; ov_we = 0; c_we = 0; tc_we = 0;
  endtask

  // inputs already driven; clock once, update model, compare at negedge
  task automatic step(string t0, string t1);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(t0, st0, exp0());
    check(t1, st1, exp1());
    idle();
  endtask

  task automatic load(logic s, logic [15:0] d);
    ld_en = 1; ld_sel = s; ld_data = d;
  endtask

  task automatic bitop(logic [2:0] s, logic v);
    bit_en = 1; bit_sel = s; bit_val = v;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5a17;
    void'($urandom(seed));
    model_reset();
    #(CLK_P * 3);
    @(negedge clk);
    check("R10 reset st0", st0, 16'h0600);
    check("R10 reset st1", st1, 16'h01EC);
    rst_ni = 1;
    @(negedge clk);

    // R1 R2 R3: loads of all ones and all zeros
    load(0, 16'hFFFF); step("R1 load0 ones", "R5 st1 untouched");
    load(1, 16'h0000); step("R6 ptr copy", "R3 rsv ones st1");
    load(1, 16'hFFFF); step("R6 st0", "R2 load1 ones");
    load(0, 16'h0000); step("R3 rsv ones st0", "R5 buf kept");
    // R5: load0 leaves intm; bit op on intm
    bitop(3'd0, 0); step("R7 intm clear", "R7 st1");
    load(0, 16'h0200); step("R5 intm kept", "R5 buf");
    load(0, 16'hFDFF); step("R5 intm kept 0", "R5 buf2");
    // R4: pointer updates
    ptr_en = 1; ptr_val = 3'd5; step("R4 ptr new", "R4 buf old");
    ptr_en = 1; ptr_val = 3'd2; step("R4 ptr new2", "R4 buf old2");
    // R8: load with pointer update
    load(0, 16'h4000); ptr_en = 1; ptr_val = 3'd7; step("R8 ptr ignored", "R8 buf kept");
    load(1, 16'hA000); ptr_en = 1; ptr_val = 3'd1; step("R8 load1 ptr", "R8 load1 buf");
    // R8: load beats bit op on same field; bit op beats flag
    load(1, 16'h0000); bitop(3'd4, 1); tc_we = 1; tc = 1; step("R8 st0", "R8 load over tc");
    bitop(3'd5, 1); c_we = 1; c = 0; step("R8 st0b", "R8 bit over carry");
    load(0, 16'h0000); bitop(3'd1, 1); step("R8 load over ovm", "R8 st1c");
    // R7: every code, and code 7
    for (int k = 0; k < 7; k++) begin bitop(3'(k), 1); step("R7 set st0", "R7 set st1"); end
    bitop(3'd7, 0); step("R7 code7 st0", "R7 code7 st1");
    for (int k = 0; k < 7; k++) begin bitop(3'(k), 0); step("R7 clr st0", "R7 clr st1"); end
    // R9: flag inputs
    ov_we = 1; ov = 1; c_we = 1; c = 1; tc_we = 1; tc = 1; step("R9 ov", "R9 c tc");
    ov_we = 1; ov = 0; tc_we = 1; tc = 0; step("R9 ov clr", "R9 tc clr");
    ov = 1; c = 0; tc = 1; step("R9 no we st0", "R9 no we st1");

    // random mix
    for (int i = 0; i < N_RAND; i++) begin
      ld_en   = ($urandom % 6) == 0;
      ld_sel  = $urandom % 2;
      ld_data = 16'($urandom);
      bit_en  = ($urandom % 3) == 0;
      bit_sel = 3'($urandom);
      bit_val = $urandom % 2;
      ptr_en  = ($urandom % 3) == 0;
      ptr_val = 3'($urandom);
      ov_we = $urandom % 2; ov = $urandom % 2;
      c_we  = $urandom % 2; c  = $urandom % 2;
      tc_we = $urandom % 2; tc = $urandom % 2;
      step("R1 rand st0", "R2 rand st1");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule